// File: doc/BRIEF.md
# Tail-Predicated Vector Loop Counter

This block steers a vector loop that walks over an arbitrary number of data elements using fixed 128-bit vectors. When software starts the loop, the block is given the total element count and the element width (8, 16 or 32 bits). Every time the datapath finishes one pass over a vector, it sends an iteration-end strobe. The block then takes one vector's worth of elements off the remaining count and decides whether another pass follows.

During each pass the block drives a 16-bit byte-lane predicate to the datapath. On full passes every lane is enabled. On the last pass fewer elements may be left than a vector holds, and then only the low-order lanes that carry real elements are enabled. The loop can therefore finish its final partial vector without any scalar epilogue code.

A count of zero at loop entry skips the body completely. A clear input abandons a running loop at any time.

Top module: `tpl_loop_ctrl`

## Requirements
- R1: While reset is asserted, and until the first accepted command after it, `busy_o` is 0, `cont_o` is 0 and `pred_o` is 16'hFFFF.
- R2: A start pulse with a non-zero count loads that count. In the next cycle `busy_o` is 1, `cont_o` pulses high for exactly one cycle, and `pred_o` shows the predicate for the loaded count.
- R3: `start_size_i` is encoded as 0 = 8-bit (16 elements per vector), 1 = 16-bit (8 elements), 2 = 32-bit (4 elements). Code 3 behaves like code 2.
- R4: An iteration-end strobe while busy lowers the remaining count by the elements-per-vector value, saturating at zero rather than wrapping. `pred_o` follows the new remaining count one cycle later. In cycles with no command, `pred_o` holds its value and `cont_o` is 0.
- R5: One cycle after an iteration-end strobe, `cont_o` is 1 for that single cycle exactly when elements remain. Otherwise `busy_o` falls to 0 in that same cycle. A count of N therefore takes ceil(N / elements-per-vector) strobes to finish.
- R6: A start pulse with a count of zero leaves `busy_o` at 0 and `cont_o` at 0, and issues no predicate (`pred_o` stays 16'hFFFF).
- R7: While busy, `pred_o` has its lowest min(remaining, elements-per-vector) × element-bytes bits set and all other bits clear. For example, 3 remaining 16-bit elements give 16'h003F.
- R8: A clear pulse abandons the loop. In the next cycle `busy_o` is 0, `cont_o` is 0 and `pred_o` is 16'hFFFF. Clear takes priority over start and iteration-end in the same cycle.
- R9: An iteration-end strobe while idle has no effect: `busy_o`, `cont_o` and `pred_o` are unchanged.
- R10: A start pulse while a loop is busy reloads the count and element size, and replaces the old loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Loop-entry pulse; loads count and size |
| start_cnt_i | input | CNT_W | Total number of elements to process |
| start_size_i | input | 2 | Element-width code (see R3) |
| iter_end_i | input | 1 | End-of-pass strobe from the datapath |
| clear_i | input | 1 | Abandon the loop |
| busy_o | output | 1 | Loop active |
| cont_o | output | 1 | One-cycle pulse: another pass follows |
| pred_o | output | VEC_BYTES | Byte-lane predicate for the current pass |

## Verification
Every result is registered once. A start, strobe or clear sampled at one rising edge therefore shows on `busy_o`, `cont_o` and `pred_o` just after that same edge and holds until the next command. The internal reset synchronizer adds two cycles after `rst_n` rises before any command is accepted.

The bench drives each command on a falling edge and removes it on the next falling edge. It samples the outputs at that second falling edge, half a cycle after the edge that registered them. It then spends one quiet cycle confirming that the predicate holds and that the continue pulse has dropped. The sweep covers every count from 0 to 40 for all four size codes, and predicts the mask and the number of passes arithmetically.

// File: rtl/tpl_pkg.sv
package tpl_pkg;

  typedef enum logic [1:0] {
    ESZ_B8  = 2'd0,
    ESZ_B16 = 2'd1,
    ESZ_B32 = 2'd2,
    ESZ_RSV = 2'd3
  } esize_e;

  // log2 of element bytes; the reserved code behaves as 32-bit
  function automatic logic [1:0] size_shift(input esize_e sz);
    case (sz)
      ESZ_B8:  size_shift = 2'd0;
      ESZ_B16: size_shift = 2'd1;
      default: size_shift = 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/tpl_rst_sync.sv
module tpl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/tpl_decr.sv
module tpl_decr
  import tpl_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int VEC_BYTES = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  esize_e           size_i,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             more_o
);
  logic [CNT_W-1:0] per_vec;

  always_comb begin
    per_vec    = CNT_W'(VEC_BYTES) >> size_shift(size_i);
    more_o     = (cnt_i > per_vec);
    cnt_next_o = more_o ? (cnt_i - per_vec) : '0;
  end
endmodule

// File: rtl/tpl_lanes.sv
module tpl_lanes
  import tpl_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int VEC_BYTES = 16,
  localparam int LW       = $clog2(VEC_BYTES) + 1
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  esize_e           size_i,
  output logic [LW-1:0]    lanes_o
);
  logic [CNT_W-1:0] per_vec;

  always_comb begin
    per_vec = CNT_W'(VEC_BYTES) >> size_shift(size_i);
    lanes_o = (cnt_i < per_vec) ? LW'(cnt_i) : LW'(per_vec);
  end
endmodule

// File: rtl/tpl_mask.sv
module tpl_mask #(
  parameter int VEC_BYTES = 16,
  localparam int LW       = $clog2(VEC_BYTES) + 1,
  localparam int BW       = LW + 2
) (
  input  logic [LW-1:0]        lanes_i,
  input  logic [1:0]           shift_i,
  output logic [VEC_BYTES-1:0] mask_o
);
  logic [BW-1:0] nbytes;

  assign nbytes = BW'(lanes_i) << shift_i;

  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
    localparam logic [BW-1:0] IDX = BW'(b);
    assign mask_o[b] = (IDX < nbytes);
  end
endmodule

// File: rtl/tpl_loop_ctrl.sv
module tpl_loop_ctrl
  import tpl_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int VEC_BYTES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     start_cnt_i,
  input  logic [1:0]           start_size_i,
  input  logic                 iter_end_i,
  input  logic                 clear_i,
  output logic                 busy_o,
  output logic                 cont_o,
  output logic [VEC_BYTES-1:0] pred_o
);
  localparam int LW = $clog2(VEC_BYTES) + 1;

  logic                 rst_n_int;
  logic [CNT_W-1:0]     cnt_q, cnt_d, dec_cnt;
  esize_e               size_q, size_d;
  logic                 busy_q, busy_d, cont_q, cont_d, dec_more;
  logic [VEC_BYTES-1:0] pred_q, pred_d, mask_d;
  logic [LW-1:0]        lanes_d;
  logic                 state_en;

  tpl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  tpl_decr #(.CNT_W(CNT_W), .VEC_BYTES(VEC_BYTES)) u_decr (
    .cnt_i(cnt_q), .size_i(size_q), .cnt_next_o(dec_cnt), .more_o(dec_more)
  );

  tpl_lanes #(.CNT_W(CNT_W), .VEC_BYTES(VEC_BYTES)) u_lanes (
    .cnt_i(cnt_d), .size_i(size_d), .lanes_o(lanes_d)
  );

  tpl_mask #(.VEC_BYTES(VEC_BYTES)) u_mask (
    .lanes_i(lanes_d), .shift_i(size_shift(size_d)), .mask_o(mask_d)
  );

  // next state: clear > start > iteration end
  always_comb begin
    cnt_d  = cnt_q;
    size_d = size_q;
    busy_d = busy_q;
    cont_d = 1'b0;
    if (clear_i) begin
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (start_i) begin
      cnt_d  = start_cnt_i;
      size_d = esize_e'(start_size_i);
      busy_d = (start_cnt_i != '0);
      cont_d = (start_cnt_i != '0);
    end else if (iter_end_i && busy_q) begin
      cnt_d  = dec_cnt;
      busy_d = dec_more;
      cont_d = dec_more;
    end
    pred_d   = busy_d ? mask_d : '1;
    state_en = clear_i | start_i | (iter_end_i & busy_q);
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cnt_q  <= '0;
      size_q <= ESZ_B8;
      busy_q <= 1'b0;
      pred_q <= '1;
    end else if (state_en) begin
      cnt_q  <= cnt_d;
      size_q <= size_d;
      busy_q <= busy_d;
      pred_q <= pred_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) cont_q <= 1'b0;
    else            cont_q <= cont_d;
  end

  assign busy_o = busy_q;
  assign cont_o = cont_q;
  assign pred_o = pred_q;
endmodule

// File: rtl/tpl_loop_ctrl_chk.sv
module tpl_loop_ctrl_chk #(
  parameter int CNT_W     = 16,
  parameter int VEC_BYTES = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic [CNT_W-1:0]     start_cnt_i,
  input logic                 iter_end_i,
  input logic                 clear_i,
  input logic                 busy_o,
  input logic                 cont_o,
  input logic [VEC_BYTES-1:0] pred_o
);
  logic [VEC_BYTES-1:0] pred_inc;
  assign pred_inc = pred_o + VEC_BYTES'(1);

  AST_IDLE_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (pred_o == '1)); // R6

  AST_CONT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cont_o |-> busy_o); // R5

  AST_CLEAR_ABANDONS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!busy_o && !cont_o)); // R8

  AST_IDLE_STROBE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i && !clear_i) |=> (!busy_o && !cont_o)); // R9

  AST_ZERO_COUNT_SKIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !clear_i && start_cnt_i == '0) |=> !busy_o); // R6

  AST_PRED_LOW_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ((pred_o != '0) && ((pred_o & pred_inc) == '0))); // R7

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !clear_i && !iter_end_i) |=> ($stable(pred_o) && !cont_o)); // R4
endmodule

bind tpl_loop_ctrl tpl_loop_ctrl_chk #(.CNT_W(CNT_W), .VEC_BYTES(VEC_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_cnt_i(start_cnt_i),
  .iter_end_i(iter_end_i), .clear_i(clear_i), .busy_o(busy_o),
  .cont_o(cont_o), .pred_o(pred_o)
);

// File: tb/tpl_loop_ctrl_test.sv
`timescale 1ns/1ps
module tpl_loop_ctrl_test;
  localparam int CNT_W = 16;
  localparam int VB    = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i, iter_end_i, clear_i;
  logic [CNT_W-1:0] start_cnt_i;
  logic [1:0] start_size_i;
  logic busy_o, cont_o;
  logic [VB-1:0] pred_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  tpl_loop_ctrl #(.CNT_W(CNT_W), .VEC_BYTES(VB)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_cnt_i(start_cnt_i),
    .start_size_i(start_size_i), .iter_end_i(iter_end_i), .clear_i(clear_i),
    .busy_o(busy_o), .cont_o(cont_o), .pred_o(pred_o)
  );

  function automatic int epv(input int sz);
    return (sz == 0) ? 16 : (sz == 1) ? 8 : 4;
  endfunction

  function automatic int ebytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [15:0] exp_mask(input int rem, input int sz);
    int lanes = (rem < epv(sz)) ? rem : epv(sz);
    int nb = lanes * ebytes(sz);
    return 16'(((32'd1 << nb) - 1));
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_out(input string req, input bit b, input bit c,
                           input logic [15:0] p);
    check(req, "busy", {31'd0, busy_o}, {31'd0, b});
    check(req, "cont", {31'd0, cont_o}, {31'd0, c});
    check(req, "pred", {16'd0, pred_o}, {16'd0, p});
  endtask

  task automatic pulse(input bit st, input int cnt, input int sz,
                       input bit ie, input bit cl);
    @(negedge clk);
    start_i = st; start_cnt_i = CNT_W'(cnt); start_size_i = 2'(sz);
    iter_end_i = ie; clear_i = cl;
    @(negedge clk);
    start_i = 0; iter_end_i = 0; clear_i = 0;
  endtask

  task automatic quiet(input string req);
    logic [15:0] p = pred_o;
    bit b = busy_o;
    @(negedge clk);
    check_out(req, b, 1'b0, p);
  endtask

  task automatic run_loop(input int n, input int sz);
    int rem = n;
    int iters = 0;
    pulse(1, n, sz, 0, 0);
    if (n == 0) check_out("R6", 0, 0, 16'hFFFF);
    else check_out("R2", 1, 1, exp_mask(n, sz));
    while (rem > 0) begin
      quiet("R4");
      pulse(0, 0, 0, 1, 0);
      iters++;
      rem = (rem > epv(sz)) ? rem - epv(sz) : 0;
      if (rem > 0) check_out("R7", 1, 1, exp_mask(rem, sz));
      else check_out("R5", 0, 0, 16'hFFFF);
    end
    check("R3", "passes", iters, (n + epv(sz) - 1) / epv(sz));
  endtask

  initial begin
    rst_n = 0; start_i = 0; iter_end_i = 0; clear_i = 0;
    start_cnt_i = '0; start_size_i = '0;
    repeat (3) @(negedge clk);
    check_out("R1", 0, 0, 16'hFFFF);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_out("R1", 0, 0, 16'hFFFF);

    // sweep of every count 0..40 over the four size codes (R3 includes code 3)
    for (int sz = 0; sz < 4; sz++)
      for (int n = 0; n <= 40; n++) run_loop(n, sz);

    // R7: worked example
    pulse(1, 3, 1, 0, 0);
    check_out("R7", 1, 1, 16'h003F);
    // R10: restart while busy with new count and size
    pulse(1, 37, 0, 0, 0);
    check_out("R10", 1, 1, 16'hFFFF);
    pulse(1, 2, 2, 0, 0);
    check_out("R10", 1, 1, 16'h00FF);
    // R8: clear beats iteration end
    pulse(0, 0, 0, 1, 1);
    check_out("R8", 0, 0, 16'hFFFF);
    // R8: clear beats start
    pulse(1, 20, 0, 0, 1);
    check_out("R8", 0, 0, 16'hFFFF);
    // R8: clear mid-loop
    pulse(1, 50, 2, 0, 0);
    pulse(0, 0, 0, 1, 0);
    check_out("R5", 1, 1, 16'hFFFF);
    pulse(0, 0, 0, 0, 1);
    check_out("R8", 0, 0, 16'hFFFF);
    // R9: strobe while idle
    pulse(0, 0, 0, 1, 0);
    check_out("R9", 0, 0, 16'hFFFF);
    quiet("R9");
    // R4: saturation - 5 bytes then one strobe ends cleanly, next strobe ignored
    pulse(1, 5, 0, 0, 0);
    check_out("R4", 1, 1, 16'h001F);
    pulse(0, 0, 0, 1, 0);
    check_out("R4", 0, 0, 16'hFFFF);
    pulse(0, 0, 0, 1, 0);
    check_out("R9", 0, 0, 16'hFFFF);
    // R4: large count stays in full vectors
    pulse(1, 16'hFFFF, 2, 0, 0);
    pulse(0, 0, 0, 1, 0);
    check_out("R4", 1, 1, 16'hFFFF);
    pulse(0, 0, 0, 0, 1);
    check_out("R8", 0, 0, 16'hFFFF);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule